// File: doc/BRIEF.md
# Three-Wire Serial Register Slave with Time Snapshot

This block lets an external host read and write a bank of sixteen 8-bit registers over a three-wire bus. The bus has a chip-enable, a serial clock and one data line. The data line is split here into an input, an output and an output enable, so that the pad ring can build the bidirectional buffer. Every bus signal is taken into the system clock domain through a two-flop synchronizer. Serial clock edges are then detected in that domain. The system clock must run at least four times faster than the serial clock.

A transaction opens when chip-enable goes high. The first byte is the address byte, sent least significant bit first. Its top bit selects the direction: 0 reads and 1 writes. Its low four bits select the starting register. Any number of data bytes may follow. After each data byte the register index advances, wrapping inside the 16-register window. The lowest NTIME registers hold a snapshot of a running time value supplied from outside. That snapshot is refreshed only when chip-enable rises, so a burst read sees one frozen instant.

The serial bus cannot be stalled, so the block has no valid/ready handshake. A write lands in the bank in the system cycle in which its eighth bit is seen, and the whole bank is visible on `bank_q` at all times.

Top module: `sdio_reg_slave`

## Requirements
- R1: Bits are taken from `sdio_in` on the rising edge of `ser_clk`, least significant bit first. The first 8 bits after `ser_ce` rises form the address byte.
- R2: Bit 7 of the address byte selects the direction (0 = read, 1 = write). Bits 3:0 select the starting register, and bits 6:4 are ignored.
- R3: In a write transaction, the register changes only after all 8 bits of a data byte have arrived, and it then holds exactly that byte.
- R4: In a read transaction, bit 0 of the selected register appears on `sdio_out` after the first `ser_clk` falling edge that follows the 8th address bit. Each later falling edge presents the next bit, least significant bit first, and the bit stays stable until the next falling edge.
- R5: After every data byte the register index advances by one. It wraps from 15 to 0: a read started at 0Fh continues at 00h, and a write started at 8Fh continues at 80h, since write addresses 80h–8Fh reach the same registers that reads reach at 00h–0Fh.
- R6: `sdio_oe` is high only during the data phase of a read transaction. It is low while `ser_ce` is low, during the address byte, and throughout a write transaction.
- R7: On every rising edge of `ser_ce`, registers 0 to NTIME-1 load byte i of `time_live`. Changes on `time_live` later in the same transaction are not visible in reads.
- R8: `ser_ce` going low at any point discards the partial byte and clears the bit counter. If `ser_ce` falls in the same synchronized cycle as the 8th bit of a data byte, no write happens.
- R9: After reset all registers read as zero and `sdio_oe` is low.
- R10: Registers NTIME to 15 are never changed by the snapshot, and a written value stays in place across later transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_ce | input | 1 | Bus chip-enable, high during a transaction |
| ser_clk | input | 1 | Bus serial clock |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Data driven toward the pad |
| sdio_oe | output | 1 | Pad output enable for the data line |
| time_live | input | NTIME*DW | Running time bytes; byte i feeds register i |
| bank_q | output | NREG*DW | All registers; register i at bits i*DW +: DW |

## Verification
Two events can land in the same system cycle: the 8th serial clock rise of a data byte, which commits the write, and the synchronized fall of chip-enable, which aborts the transaction. The bench provokes this by driving the serial clock high and chip-enable low in the same step. Both signals pass through synchronizers of equal depth, so the design sees the two events together. The abort must win: the target register must keep its old value, and a full write issued right afterwards must land intact, which shows the bit counter was cleared.

// File: rtl/sdio_reg_pkg.sv
package sdio_reg_pkg;
  // transaction phase of the serial front end
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2
  } phase_e;
endpackage

// File: rtl/sdio_reg_sync.sv
module sdio_reg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff <= '0;
    else        ff <= {ff[STAGES-2:0], d};
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/sdio_reg_frontend.sv
module sdio_reg_frontend import sdio_reg_pkg::*; #(
  parameter int NREG = 16,
  parameter int DW   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_s,
  input  logic                     din_s,
  input  logic                     sclk_rise,
  input  logic                     sclk_fall,
  input  logic [DW-1:0]            rd_word,
  output logic [$clog2(NREG)-1:0]  rd_sel,
  output logic                     we,
  output logic [$clog2(NREG)-1:0]  widx,
  output logic [DW-1:0]            wdata,
  output logic                     rd_phase,
  output logic                     sdo
);
  localparam int AW = $clog2(NREG);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  phase_e          phase;
  logic [BW-1:0]   bcnt;
  logic [BW-1:0]   ocnt;
  logic [DW-1:0]   shin;
  logic [DW-1:0]   osh;
  logic [AW-1:0]   addr;
  logic [DW-1:0]   full;
  logic            last;

  // the byte as it stands once the current bit is shifted in (LSB first)
  assign full = {din_s, shin[DW-1:1]};
  assign last = (bcnt == LAST_BIT);

  // register fetched at a byte boundary: start address, or the next one
  assign rd_sel = (phase == PH_ADDR) ? full[AW-1:0] : addr + AW'(1);

  assign we       = ce_s && sclk_rise && last && (phase == PH_WR);
  assign widx     = addr;
  assign wdata    = full;
  assign rd_phase = (phase == PH_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_ADDR;
      bcnt  <= '0;
      ocnt  <= '0;
      shin  <= '0;
      osh   <= '0;
      addr  <= '0;
      sdo   <= 1'b0;
    end else if (!ce_s) begin
      // idle or aborted: ready for a fresh address byte
      phase <= PH_ADDR;
      bcnt  <= '0;
      ocnt  <= '0;
      shin  <= '0;
      sdo   <= 1'b0;
    end else begin
      if (sclk_rise) begin
        shin <= full;
        bcnt <= bcnt + BW'(1);
        if (last) begin
          unique case (phase)
            PH_ADDR: begin
              addr  <= full[AW-1:0];
              phase <= full[DW-1] ? PH_WR : PH_RD;
              osh   <= rd_word;
              ocnt  <= '0;
            end
            PH_WR: begin
              addr <= addr + AW'(1);
            end
            PH_RD: begin
              addr <= addr + AW'(1);
              osh  <= rd_word;
              ocnt <= '0;
            end
            default: phase <= PH_ADDR;
          endcase
        end
      end
      if (sclk_fall && phase == PH_RD) begin
        sdo  <= osh[ocnt];
        ocnt <= ocnt + BW'(1);
      end
    end
  end
endmodule

// File: rtl/sdio_reg_bank.sv
module sdio_reg_bank #(
  parameter int NREG  = 16,
  parameter int DW    = 8,
  parameter int NTIME = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     snap,
  input  logic [NTIME*DW-1:0]      time_live,
  input  logic                     we,
  input  logic [$clog2(NREG)-1:0]  widx,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0]  rd_sel,
  output logic [DW-1:0]            rd_word,
  output logic [NREG*DW-1:0]       bank_q
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] mem [NREG];

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i < NTIME) begin : g_time
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                          mem[i] <= '0;
          else if (snap)                       mem[i] <= time_live[i*DW +: DW];
          else if (we && widx == AW'(i))       mem[i] <= wdata;
        end
      end else begin : g_user
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)                          mem[i] <= '0;
          else if (we && widx == AW'(i))       mem[i] <= wdata;
        end
      end
      assign bank_q[i*DW +: DW] = mem[i];
    end
  endgenerate

  assign rd_word = mem[rd_sel];
endmodule

// File: rtl/sdio_reg_slave.sv
module sdio_reg_slave import sdio_reg_pkg::*; #(
  parameter int NREG        = 16,
  parameter int DW          = 8,
  parameter int NTIME       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_ce,
  input  logic                 ser_clk,
  input  logic                 sdio_in,
  output logic                 sdio_out,
  output logic                 sdio_oe,
  input  logic [NTIME*DW-1:0]  time_live,
  output logic [NREG*DW-1:0]   bank_q
);
  localparam int AW  = $clog2(NREG);
  localparam int NIN = 3;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] synced;
  logic           ce_s, sclk_s, din_s;
  logic           ce_d, sclk_d;
  logic           ce_rise, sclk_rise, sclk_fall;
  logic           we, rd_phase;
  logic [AW-1:0]  widx, rd_sel;
  logic [DW-1:0]  wdata, rd_word;

  // equal-depth synchronizers keep the three bus lines aligned
  assign raw_in = {sdio_in, ser_clk, ser_ce};

  generate
    for (genvar g = 0; g < NIN; g++) begin : g_sync
      sdio_reg_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in[g]),
        .q     (synced[g])
      );
    end
  endgenerate

  assign ce_s   = synced[0];
  assign sclk_s = synced[1];
  assign din_s  = synced[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      ce_d   <= ce_s;
      sclk_d <= sclk_s;
    end
  end

  assign ce_rise   = ce_s & ~ce_d;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  sdio_reg_frontend #(.NREG(NREG), .DW(DW)) i_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_s      (ce_s),
    .din_s     (din_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .rd_word   (rd_word),
    .rd_sel    (rd_sel),
    .we        (we),
    .widx      (widx),
    .wdata     (wdata),
    .rd_phase  (rd_phase),
    .sdo       (sdio_out)
  );

  sdio_reg_bank #(.NREG(NREG), .DW(DW), .NTIME(NTIME)) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .snap      (ce_rise),
    .time_live (time_live),
    .we        (we),
    .widx      (widx),
    .wdata     (wdata),
    .rd_sel    (rd_sel),
    .rd_word   (rd_word),
    .bank_q    (bank_q)
  );

  assign sdio_oe = ce_s & rd_phase;
endmodule

// File: rtl/sdio_reg_slave_chk.sv
module sdio_reg_slave_chk #(
  parameter int NREG = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ce_s,
  input logic                    ce_rise,
  input logic                    sclk_rise,
  input logic                    sclk_fall,
  input logic                    sdio_oe,
  input logic                    sdio_out,
  input logic                    we,
  input logic [$clog2(NREG)-1:0] widx
);
  localparam int AW = $clog2(NREG);

  logic [7:0]    rcnt;
  logic [AW-1:0] prev_idx;
  logic          have_prev;

  // serial rises seen since chip-enable went high (saturating)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt      <= '0;
      prev_idx  <= '0;
      have_prev <= 1'b0;
    end else if (!ce_s) begin
      rcnt      <= '0;
      have_prev <= 1'b0;
    end else begin
      if (sclk_rise && rcnt != 8'hFF) rcnt <= rcnt + 8'd1;
      if (we) begin
        prev_idx  <= widx;
        have_prev <= 1'b1;
      end
    end
  end

  // R6: fresh transaction starts in the address phase, line not driven
  a_r6_quiet_on_ce_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ce_rise |-> !sdio_oe);

  // R4: output bit changes only on a serial falling edge
  a_r4_out_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_s && !sclk_fall) |=> $stable(sdio_out));

  // R3: a write commits on the last bit of a data byte after the address byte
  a_r3_write_on_byte_edge: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (rcnt[2:0] == 3'd7 && rcnt >= 8'd15));

  // R3: a write is a single-cycle event
  a_r3_single_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we);

  // R5: consecutive writes in one burst go to consecutive registers
  a_r5_write_index_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (we && have_prev) |-> (widx == prev_idx + AW'(1)));
endmodule

bind sdio_reg_slave sdio_reg_slave_chk #(.NREG(NREG)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ce_s      (ce_s),
  .ce_rise   (ce_rise),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall),
  .sdio_oe   (sdio_oe),
  .sdio_out  (sdio_out),
  .we        (we),
  .widx      (widx)
);

// File: tb/test_sdio_reg_slave.sv
module test_sdio_reg_slave;
  localparam int NREG  = 16;
  localparam int DW    = 8;
  localparam int NTIME = 7;
  localparam int HALF  = 6;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                ser_ce = 1'b0;
  logic                ser_clk = 1'b0;
  logic                sdio_in = 1'b0;
  logic                sdio_out;
  logic                sdio_oe;
  logic [NTIME*DW-1:0] time_live = '0;
  logic [NREG*DW-1:0]  bank_q;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NREG];

  always #4 clk = ~clk;

  sdio_reg_slave #(.NREG(NREG), .DW(DW), .NTIME(NTIME)) i_sdio_reg_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_ce    (ser_ce),
    .ser_clk   (ser_clk),
    .sdio_in   (sdio_in),
    .sdio_out  (sdio_out),
    .sdio_oe   (sdio_oe),
    .time_live (time_live),
    .bank_q    (bank_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit slot: drive, wait low half, sample output, rise, wait, fall
  task automatic slot(input logic b, output logic so, output logic oe);
    sdio_in = b;
    wait_c(HALF);
    so = sdio_out;
    oe = sdio_oe;
    ser_clk = 1'b1;
    wait_c(HALF);
    ser_clk = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] got, output logic [7:0] oes);
    for (int i = 0; i < 8; i++) slot(b[i], got[i], oes[i]);
  endtask

  task automatic begin_xfer();
    ser_ce = 1'b1;
    for (int i = 0; i < NTIME; i++) model[i] = time_live[i*DW +: DW];
    wait_c(HALF);
  endtask

  task automatic end_xfer();
    wait_c(HALF);
    ser_ce = 1'b0;
    wait_c(2 * HALF);
  endtask

  function automatic logic [7:0] tbyte(input int seed, input int i);
    return 8'((seed * 53 + i * 29 + 7) & 8'hFF);
  endfunction

  task automatic set_time(input int seed);
    for (int i = 0; i < NTIME; i++) time_live[i*DW +: DW] = tbyte(seed, i);
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, 32'(bank_q[i*DW +: DW]), 32'(model[i]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] got, oes, a;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wait_c(4);
    rst_n = 1'b1;
    wait_c(2);

    // R9: reset state
    check_bank("R9 reset bank");
    chk("R9 reset oe", 32'(sdio_oe), 32'd0);

    // Write bursts, start at several indices, 18 bytes each to force the wrap.
    // R2: upper address bits 6:4 carry noise; R5: 8Fh wraps to 80h
    for (int s = 0; s < NREG; s += 5) begin
      set_time(s + 100);
      begin_xfer();
      // R7: snapshot loaded on chip-enable rise
      for (int i = 0; i < NTIME; i++)
        chk("R7 snapshot on ce rise", 32'(bank_q[i*DW +: DW]), 32'(tbyte(s + 100, i)));
      a = 8'h80 | 8'(((s * 3) & 7) << 4) | 8'(s);
      xfer_byte(a, got, oes);
      chk("R6 oe low in address byte (write)", 32'(oes), 32'd0);
      for (int k = 0; k < 18; k++) begin
        logic [7:0] v;
        v = 8'((s * 37 + k * 11 + 1) & 8'hFF);
        xfer_byte(v, got, oes);
        chk("R6 oe low during write data", 32'(oes), 32'd0);
        model[(s + k) % NREG] = v;
      end
      end_xfer();
      chk("R6 oe low with ce low", 32'(sdio_oe), 32'd0);
      // R1 R2 R3 R5: whole bank matches the model after the burst
      check_bank("R3 R5 burst write result");
    end

    // Read bursts from every start index, 18 bytes each.
    // R4 R5: LSB-first output, wrap 0Fh -> 00h; R7: frozen time; R10: persistence
    for (int s = 0; s < NREG; s++) begin
      set_time(s);
      begin_xfer();
      a = 8'(((s & 7) << 4) | s);
      xfer_byte(a, got, oes);
      chk("R6 oe low in address byte (read)", 32'(oes), 32'd0);
      set_time(s + 50); // must not show in this transaction (R7)
      for (int k = 0; k < 18; k++) begin
        xfer_byte(8'h00, got, oes);
        chk("R4 R5 R7 R10 read data", 32'(got), 32'(model[(s + k) % NREG]));
        chk("R6 oe high in read data", 32'(oes), 32'hFF);
      end
      end_xfer();
      chk("R6 oe low after read", 32'(sdio_oe), 32'd0);
    end

    // R8: abort in mid data byte leaves register 9 untouched
    begin_xfer();
    xfer_byte(8'h89, got, oes);
    for (int i = 0; i < 5; i++) slot(1'b1, got[i], oes[i]);
    end_xfer();
    check_bank("R8 partial byte discarded");

    // R8: abort in mid address byte, then a clean read of register 9
    begin_xfer();
    for (int i = 0; i < 3; i++) slot(1'b1, got[i], oes[i]);
    end_xfer();
    begin_xfer();
    xfer_byte(8'h09, got, oes);
    xfer_byte(8'h00, got, oes);
    end_xfer();
    chk("R8 read after address abort", 32'(got), 32'(model[9]));

    // R8: chip-enable falls together with the 8th data bit rise
    begin_xfer();
    xfer_byte(8'h89, got, oes);
    for (int i = 0; i < 7; i++) slot(1'b0, got[i], oes[i]);
    sdio_in = 1'b1;
    wait_c(HALF);
    ser_clk = 1'b1;
    ser_ce  = 1'b0;
    wait_c(HALF);
    ser_clk = 1'b0;
    wait_c(2 * HALF);
    chk("R8 coincident abort blocks write", 32'(bank_q[9*DW +: DW]), 32'(model[9]));

    // R8 R3: next full write lands intact (bit counter was cleared)
    begin_xfer();
    xfer_byte(8'h89, got, oes);
    xfer_byte(8'hA5, got, oes);
    end_xfer();
    model[9] = 8'hA5;
    chk("R3 R8 single-byte write after abort", 32'(bank_q[9*DW +: DW]), 32'hA5);

    // R7 R10: a new chip-enable rise refreshes time regs only
    set_time(77);
    begin_xfer();
    end_xfer();
    check_bank("R7 R10 snapshot scope");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule